// File: doc/BRIEF.md
# UART Interrupt Mask and Request Router

This block keeps the interrupt enable mask of a UART and turns the UART core's level status conditions into three request outputs: one for transmit, one for receive and one for status events. Software reaches the single mask through three aliased views selected by a 2-bit view code. The direct view replaces the whole mask. The set view turns on the bits written as one. The clear view turns off the bits written as one. Every view reads back the current mask.

Transmit and receive requests normally travel toward a DMA engine. For each direction a flag output tells whether the request qualifies as a DMA request, which happens when that direction's DMA channel is enabled. When it is not enabled, the request is an ordinary interrupt. The status output goes straight to the system interrupt controller. A fold mode bit in the mask sends the transmit and receive requests into the status output instead. Interrupt-driven operation then needs no DMA channel.

All request outputs are registered, so they follow their inputs with one clock of latency.

Top module: `uart_irq_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mask becomes 0. `tx_req`, `tx_to_dma`, `rx_req`, `rx_to_dma` and `stat_irq` become 0, and a read of the mask returns 0.
- R2: A write with `bus_view` = 0 (direct) to the block address replaces the whole 5-bit mask with `bus_wdata` at that clock edge.
- R3: A write with `bus_view` = 1 (set) to the block address turns on every mask bit that is one in `bus_wdata` and leaves the other bits unchanged.
- R4: A write with `bus_view` = 2 (clear) to the block address turns off every mask bit that is one in `bus_wdata` and leaves the other bits unchanged.
- R5: With `bus_addr` equal to the block address, `bus_rdata` shows the current mask whatever the view code. With any other address it shows 0. Writes with `bus_view` = 3, and writes to any other address, leave the mask unchanged.
- R6: The receive source is active when (mask bit 0 and `rx_full`) or (mask bit 4 and `rx_slow`). Mask bit 4 gates the reduced-rate receive condition. `rx_req` equals the receive source when mask bit 3 is 0.
- R7: The transmit source is mask bit 1 and `tx_empty`. `tx_req` equals the transmit source when mask bit 3 is 0.
- R8: `stat_irq` is high when mask bit 2 is set and any bit of `line_err` is high. The status path never produces a DMA flag.
- R9: When mask bit 3 (fold mode) is set, `tx_req` and `rx_req` are 0. `stat_irq` is then also high whenever the transmit source or the receive source is active.
- R10: `tx_to_dma` equals `tx_req` AND `tx_dma_en`. `rx_to_dma` equals `rx_req` AND `rx_dma_en`.
- R11: Every request output reflects the mask and inputs present at the previous clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_view | input | 2 | View code: 0 direct, 1 set, 2 clear, 3 none |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Read data, the mask on an address match |
| rx_full | input | 1 | Receive buffer full level |
| tx_empty | input | 1 | Transmit buffer empty level |
| line_err | input | ERR_W (3) | Line error levels |
| rx_slow | input | 1 | Reduced-rate receive condition |
| tx_dma_en | input | 1 | Transmit DMA channel enabled |
| rx_dma_en | input | 1 | Receive DMA channel enabled |
| tx_req | output | 1 | Transmit request |
| tx_to_dma | output | 1 | Transmit request qualifies as DMA request |
| rx_req | output | 1 | Receive request |
| rx_to_dma | output | 1 | Receive request qualifies as DMA request |
| stat_irq | output | 1 | Status interrupt |

## Verification
A corrupted mask bit shows at `bus_rdata` in the same cycle it is read. It also shows on the request outputs one edge after a source condition it gates goes active. The bench therefore reads the mask back after every set, clear and direct write, over all pairs of starting value and write data. It then sweeps all 32 mask values against every combination of source and DMA-enable inputs, and compares all five outputs one edge after each change. A wrong fold or DMA qualification shows within that single cycle as a request on the wrong output.

// File: rtl/uirq_pkg.sv
// Shared constants and types for the UART interrupt mask and request router.
// Assumes a 5-bit mask whose bit positions are fixed by the register layout.
package uirq_pkg;
    localparam int MASK_W = 5;
    localparam int B_RXF  = 0;  // receive buffer full enable
    localparam int B_TXE  = 1;  // transmit buffer empty enable
    localparam int B_LER  = 2;  // line error enable
    localparam int B_FOLD = 3;  // fold transmit/receive into status
    localparam int B_RXS  = 4;  // reduced-rate receive enable

    typedef enum logic [1:0] {
        VIEW_DIRECT = 2'd0,
        VIEW_SET    = 2'd1,
        VIEW_CLEAR  = 2'd2,
        VIEW_NONE   = 2'd3
    } view_e;

    typedef struct packed {
        logic stat;
        logic rx_dma;
        logic rx;
        logic tx_dma;
        logic tx;
    } req_t;
endpackage

// File: rtl/uirq_mask_reg.sv
// Mask register with three aliased write views and a common read view.
// Assumes single-cycle bus accesses; a write takes effect at the edge
// where bus_wr is sampled high with a matching address.
module uirq_mask_reg
    import uirq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_view,
    input  logic              bus_wr,
    input  logic [MASK_W-1:0] bus_wdata,
    output logic [MASK_W-1:0] bus_rdata,
    output logic [MASK_W-1:0] mask_q
);
    logic              hit;
    logic [MASK_W-1:0] mask_d;
    view_e             view;

    assign hit  = (bus_addr == BASE_ADDR);
    assign view = view_e'(bus_view);

    // Next mask value for the selected view.
    always_comb begin
        mask_d = mask_q;
        if (hit && bus_wr) begin
            case (view)
                VIEW_DIRECT: mask_d = bus_wdata;
                VIEW_SET:    mask_d = mask_q | bus_wdata;
                VIEW_CLEAR:  mask_d = mask_q & ~bus_wdata;
                default:     mask_d = mask_q;
            endcase
        end
    end

    // Mask storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Read returns the mask for every view on an address match.
    always_comb begin
        bus_rdata = hit ? mask_q : '0;
    end
endmodule

// File: rtl/uirq_source_gate.sv
// Combines the UART level conditions with their mask enables into three
// request sources. Purely combinational; assumes level-held inputs.
module uirq_source_gate
    import uirq_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input  logic [MASK_W-1:0] mask_q,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic [ERR_W-1:0]  line_err,
    input  logic              rx_slow,
    output logic              tx_src,
    output logic              rx_src,
    output logic              st_src
);
    logic [ERR_W-1:0] err_en;

    // One enabled term per line error condition.
    for (genvar g = 0; g < ERR_W; g++) begin : g_err
        assign err_en[g] = mask_q[B_LER] & line_err[g];
    end

    // Source terms for each request class.
    always_comb begin
        tx_src = mask_q[B_TXE] & tx_empty;
        rx_src = (mask_q[B_RXF] & rx_full) | (mask_q[B_RXS] & rx_slow);
        st_src = |err_en;
    end
endmodule

// File: rtl/uirq_route.sv
// Routes sources to the outputs, applying fold mode and DMA qualification,
// then registers the result. Assumes one cycle of latency is acceptable.
module uirq_route
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fold,
    input  logic tx_src,
    input  logic rx_src,
    input  logic st_src,
    input  logic tx_dma_en,
    input  logic rx_dma_en,
    output req_t req_q
);
    localparam int NDIR = 2;
    logic [NDIR-1:0] dir_src, dir_en, dir_req, dir_dma;
    req_t            req_d;

    assign dir_src = {rx_src, tx_src};
    assign dir_en  = {rx_dma_en, tx_dma_en};

    // Per-direction request and DMA qualification.
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        assign dir_req[d] = dir_src[d] & ~fold;
        assign dir_dma[d] = dir_req[d] & dir_en[d];
    end

    // Assemble the next output word, folding into status when asked.
    always_comb begin
        req_d.tx     = dir_req[0];
        req_d.tx_dma = dir_dma[0];
        req_d.rx     = dir_req[1];
        req_d.rx_dma = dir_dma[1];
        req_d.stat   = st_src | (fold & (|dir_src));
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/uart_irq_router.sv
// Top of the UART interrupt mask and request router. Holds the mask,
// gates the level conditions and drives registered request outputs.
// Assumes synchronous active-low reset and a single-cycle register bus.
module uart_irq_router
    import uirq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter int                ERR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_view,
    input  logic              bus_wr,
    input  logic [MASK_W-1:0] bus_wdata,
    output logic [MASK_W-1:0] bus_rdata,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic [ERR_W-1:0]  line_err,
    input  logic              rx_slow,
    input  logic              tx_dma_en,
    input  logic              rx_dma_en,
    output logic              tx_req,
    output logic              tx_to_dma,
    output logic              rx_req,
    output logic              rx_to_dma,
    output logic              stat_irq
);
    logic [MASK_W-1:0] mask_q;
    logic              tx_src, rx_src, st_src;
    req_t              req_q;

    uirq_mask_reg #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_mask (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_view(bus_view),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mask_q(mask_q)
    );

    uirq_source_gate #(.ERR_W(ERR_W)) u_gate (
        .mask_q(mask_q), .rx_full(rx_full), .tx_empty(tx_empty),
        .line_err(line_err), .rx_slow(rx_slow),
        .tx_src(tx_src), .rx_src(rx_src), .st_src(st_src)
    );

    uirq_route u_route (
        .clk(clk), .rst_n(rst_n), .fold(mask_q[B_FOLD]),
        .tx_src(tx_src), .rx_src(rx_src), .st_src(st_src),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .req_q(req_q)
    );

    assign tx_req    = req_q.tx;
    assign tx_to_dma = req_q.tx_dma;
    assign rx_req    = req_q.rx;
    assign rx_to_dma = req_q.rx_dma;
    assign stat_irq  = req_q.stat;
endmodule

// File: rtl/uirq_checker.sv
// Assertion checker for uart_irq_router, attached with bind below.
// Assumes the mask register is visible as mask_q in the top module.
module uirq_checker
    import uirq_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_view,
    input logic              bus_wr,
    input logic [MASK_W-1:0] bus_wdata,
    input logic [MASK_W-1:0] mask_q,
    input logic              tx_req,
    input logic              tx_to_dma,
    input logic              rx_req,
    input logic              rx_to_dma,
    input logic              stat_irq
);
    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == BASE_ADDR);

    AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_view == 2'd0) |=> mask_q == $past(bus_wdata)); // R2
    AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_view == 2'd1) |=> mask_q == ($past(mask_q) | $past(bus_wdata))); // R3
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_view == 2'd2) |=> mask_q == ($past(mask_q) & ~$past(bus_wdata))); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit || bus_view == 2'd3) |=> $stable(mask_q)); // R5
    AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[B_RXF] && !mask_q[B_RXS]) |=> (!rx_req && !rx_to_dma)); // R6
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[B_TXE] |=> (!tx_req && !tx_to_dma)); // R7
    AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q[B_LER] && !mask_q[B_FOLD]) |=> !stat_irq); // R8
    AST_FOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[B_FOLD] |=> (!tx_req && !rx_req)); // R9
    AST_DMA_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((!tx_to_dma || tx_req) && (!rx_to_dma || rx_req))); // R10
endmodule

bind uart_irq_router uirq_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_view(bus_view),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mask_q(mask_q),
    .tx_req(tx_req), .tx_to_dma(tx_to_dma), .rx_req(rx_req),
    .rx_to_dma(rx_to_dma), .stat_irq(stat_irq)
);

// File: tb/tb_uart_irq_router.sv
module tb_uart_irq_router;
    localparam int         ADDR_W = 8;
    localparam logic [7:0] BASE   = 8'h40;
    localparam int         ERR_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0]        bus_view = '0;
    logic              bus_wr = 1'b0;
    logic [4:0]        bus_wdata = '0;
    logic [4:0]        bus_rdata;
    logic              rx_full = 0, tx_empty = 0, rx_slow = 0;
    logic [ERR_W-1:0]  line_err = '0;
    logic              tx_dma_en = 0, rx_dma_en = 0;
    logic              tx_req, tx_to_dma, rx_req, rx_to_dma, stat_irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    uart_irq_router #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .ERR_W(ERR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_view(bus_view),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_full(rx_full), .tx_empty(tx_empty), .line_err(line_err),
        .rx_slow(rx_slow), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_req(tx_req), .tx_to_dma(tx_to_dma), .rx_req(rx_req),
        .rx_to_dma(rx_to_dma), .stat_irq(stat_irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write, driven at the falling edge, taken at the next rising edge.
    task automatic bus_write(input logic [7:0] a, input logic [1:0] v, input logic [4:0] d);
        @(negedge clk);
        bus_addr = a; bus_view = v; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = BASE;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [1:0] v,
                            input logic [4:0] exp);
        bus_addr = a; bus_view = v;
        #1;
        chk(tag, {3'b0, bus_rdata}, {3'b0, exp});
        bus_addr = BASE;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset with all conditions active
        rx_full = 1; tx_empty = 1; line_err = '1; rx_slow = 1; tx_dma_en = 1; rx_dma_en = 1;
        bus_addr = BASE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 outputs", {3'b0, tx_req, tx_to_dma, rx_req, rx_to_dma, stat_irq}, 8'h0);
        read_chk("R1 mask", BASE, 2'd0, 5'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after release", {3'b0, tx_req, tx_to_dma, rx_req, rx_to_dma, stat_irq}, 8'h0);

        // R2, R3, R4: every start value against every write data
        for (int a = 0; a < 32; a++) begin
            for (int d = 0; d < 32; d++) begin
                bus_write(BASE, 2'd0, 5'(a));
                read_chk("R2 direct", BASE, 2'd0, 5'(a));
                bus_write(BASE, 2'd1, 5'(d));
                read_chk("R3 set", BASE, 2'd1, 5'(a | d));
                bus_write(BASE, 2'd0, 5'(a));
                bus_write(BASE, 2'd2, 5'(d));
                read_chk("R4 clear", BASE, 2'd2, 5'(a & ~d));
            end
        end

        // R5: read views, wrong address, view 3
        bus_write(BASE, 2'd0, 5'h15);
        read_chk("R5 view1 read", BASE, 2'd1, 5'h15);
        read_chk("R5 view3 read", BASE, 2'd3, 5'h15);
        read_chk("R5 other address read", 8'h41, 2'd0, 5'h00);
        bus_write(BASE, 2'd3, 5'h0A);
        read_chk("R5 view3 write ignored", BASE, 2'd0, 5'h15);
        bus_write(8'h41, 2'd0, 5'h0A);
        read_chk("R5 other address write ignored", BASE, 2'd0, 5'h15);
        bus_write(8'h00, 2'd1, 5'h0A);
        read_chk("R5 other address set ignored", BASE, 2'd0, 5'h15);

        // R11: latency of exactly one edge
        bus_write(BASE, 2'd0, 5'h02);
        @(negedge clk);
        tx_empty = 0;
        @(negedge clk);
        chk("R11 low", {7'b0, tx_req}, 8'h0);
        tx_empty = 1;
        #1;
        chk("R11 not before edge", {7'b0, tx_req}, 8'h0);
        @(negedge clk);
        chk("R11 after one edge", {7'b0, tx_req}, 8'h1);

        // R6..R10: every mask value against every input pattern
        for (int m = 0; m < 32; m++) begin
            bus_write(BASE, 2'd0, 5'(m));
            for (int i = 0; i < 256; i++) begin
                logic [4:0] mm;
                logic [7:0] iv;
                logic       txs, rxs_, sts, fld, etx, erx, est;
                mm = 5'(m); iv = 8'(i);
                rx_full = iv[0]; tx_empty = iv[1]; line_err = iv[4:2];
                rx_slow = iv[5]; tx_dma_en = iv[6]; rx_dma_en = iv[7];
                @(negedge clk);
                fld  = mm[3];
                txs  = mm[1] & iv[1];
                rxs_ = (mm[0] & iv[0]) | (mm[4] & iv[5]);
                sts  = mm[2] & (iv[4:2] != 3'b0);
                etx  = txs & ~fld;
                erx  = rxs_ & ~fld;
                est  = sts | (fld & (txs | rxs_));
                chk("R7 tx_req", {7'b0, tx_req}, {7'b0, etx});
                chk("R6 rx_req", {7'b0, rx_req}, {7'b0, erx});
                if (fld) chk("R9 stat_irq folded", {7'b0, stat_irq}, {7'b0, est});
                else     chk("R8 stat_irq", {7'b0, stat_irq}, {7'b0, est});
                chk("R10 tx_to_dma", {7'b0, tx_to_dma}, {7'b0, etx & iv[6]});
                chk("R10 rx_to_dma", {7'b0, rx_to_dma}, {7'b0, erx & iv[7]});
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule